// File: doc/BRIEF.md
# Debug Access Security Lock

This block sits between an in-circuit debug port and the on-chip flash and memory. It decides, one command at a time, whether a debug operation may proceed. It keeps one sticky protection bit. That bit models a cell held in non-volatile storage, so an ordinary chip reset does not erase it. Firmware may set the bit only during the pre-boot interval, which is the phase that runs before the main boot sequence. Once the bit is set, the only debug operation that is let through is a whole-chip flash erase. Every other operation is turned away.

Clearing the bit takes two steps in a fixed order. First, the flash engine signals that a global erase has finished, and the block records a pending-clear flag. Second, a chip reset arrives. At that reset the bit drops, but only if the flag was set. A reset with no completed erase before it leaves the bit set. An erase report with no reset after it also leaves the bit set.

Debug commands arrive on a valid/ready port. `cmd_ready` is high only when the block is out of reset and no decision is waiting to be presented. A command is taken on the clock edge where `cmd_valid` and `cmd_ready` are both high. The requester must hold `cmd_valid` and `cmd_code` steady until that edge. After each accepted command, `cmd_ready` falls for one cycle. This gives every decision its own separate pulse, so the port takes at most one command every two cycles.

Top module: `dbg_sec_lock`

## Requirements
- R1: While `nv_init_n` is low, `locked` and `clr_pending` go to 0, and `cmd_grant` and `cmd_reject` stay at 0. While `rst_n` is low, `cmd_ready` is 0.
- R2: While `locked` is 0, every accepted command code from 0 to 7 is granted. `cmd_grant` is high for the one cycle after the accepting edge, and `grant_code` then equals the accepted code.
- R3: A high `fw_arm`, sampled while `preboot` is high and the pre-boot window is still open, sets `locked` on the next cycle.
- R4: The pre-boot window closes the first cycle `preboot` is seen low after a reset, and it stays closed until the next reset. A `fw_arm` while the window is closed leaves `locked` unchanged, even if `preboot` has gone high again.
- R5: While `locked` is 1, an accepted command with code 3'b111 (global erase) is granted. Every other accepted code (0 to 6) gets `cmd_reject` and no grant.
- R6: Each accepted command produces exactly one result: a one-cycle pulse on either `cmd_grant` or `cmd_reject`, never both. `cmd_ready` is 0 in the cycle after an accepting edge.
- R7: An `erase_done` pulse while `locked` is 1 sets `clr_pending` on the next cycle, and `locked` stays 1 until a reset. An `erase_done` pulse while `locked` is 0 leaves `clr_pending` at 0.
- R8: A chip reset (`rst_n` low) while `clr_pending` is 1 clears both `locked` and `clr_pending`. A chip reset while `clr_pending` is 0 leaves `locked` as it was.
- R9: A firmware arm that is accepted after a global erase has completed cancels the pending clear. `clr_pending` returns to 0, and a later reset leaves `locked` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_init_n | input | 1 | Active-low, synchronous; loads the blank state into the modelled non-volatile lock cell |
| rst_n | input | 1 | Active-low synchronous chip reset |
| preboot | input | 1 | High while pre-boot firmware is running |
| fw_arm | input | 1 | Firmware request to set the lock |
| cmd_valid | input | 1 | A debug command is offered |
| cmd_ready | output | 1 | The block can take a command this cycle |
| cmd_code | input | 3 | Debug operation code; 3'b111 is global erase |
| erase_done | input | 1 | One-cycle pulse when a global flash erase has finished |
| cmd_grant | output | 1 | One-cycle pulse: the accepted command may proceed |
| cmd_reject | output | 1 | One-cycle pulse: the accepted command is blocked |
| grant_code | output | 3 | Code of the most recent decided command |
| locked | output | 1 | Security lock state |
| clr_pending | output | 1 | A completed global erase is waiting for a reset to clear the lock |

## Verification
Every result is registered once. A grant or reject pulse, the drop of `cmd_ready`, a change of `locked` after an arm, and a change of `clr_pending` after an erase report all appear in the cycle after the edge that samples the stimulus. The bench changes inputs on falling edges. It reads results at the next falling edge, which is half a cycle after that sampling edge, and reads again one cycle later to confirm that each pulse lasts only one cycle. Reset effects are read after `rst_n` has been released, once the held state can be observed again through the ports.

// File: rtl/dbg_lock_pkg.sv
package dbg_lock_pkg;
  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CODE_ERASE_ALL = 3'b111;

  typedef logic [CMD_W-1:0] cmd_code_t;

  typedef enum logic [1:0] {
    DEC_NONE   = 2'b00,
    DEC_GRANT  = 2'b01,
    DEC_REJECT = 2'b10
  } dec_e;
endpackage

// File: rtl/dbg_boot_window.sv
module dbg_boot_window (
  input  logic clk,
  input  logic nv_init_n,
  input  logic rst_n,
  input  logic preboot,
  input  logic fw_arm,
  output logic arm_ok
);
  logic win_q;

  // The window reopens only at a reset; once pre-boot is seen low it stays shut.
  always_ff @(posedge clk) begin
    if (!nv_init_n || !rst_n) win_q <= 1'b1;
    else if (!preboot)        win_q <= 1'b0;
  end

  assign arm_ok = fw_arm && preboot && win_q && rst_n && nv_init_n;

  AST_WIN_STAYS_SHUT: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
    !preboot |=> !win_q) else $error("window open after preboot fell"); // R4
endmodule

// File: rtl/dbg_lock_store.sv
module dbg_lock_store (
  input  logic clk,
  input  logic nv_init_n,
  input  logic rst_n,
  input  logic arm_ok,
  input  logic erase_done,
  output logic lock_o,
  output logic pend_o
);
  logic lock_q, pend_q;

  // Lock is a non-volatile cell: chip reset only acts on it through the pending flag.
  always_ff @(posedge clk) begin
    if (!nv_init_n) begin
      lock_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (!rst_n) begin
      if (pend_q) lock_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (arm_ok) begin
      lock_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (erase_done && lock_q) begin
      pend_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
  assign pend_o = pend_q;

  AST_LOCK_ARMED_ONLY: assert property (@(posedge clk) disable iff (!nv_init_n)
    $rose(lock_q) |-> $past(arm_ok)) else $error("lock rose without arm"); // R3
  AST_CLEAR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!nv_init_n)
    $fell(lock_q) |-> $past(!rst_n && pend_q)) else $error("lock fell without erase+reset"); // R8
  AST_ERASE_RECORDED: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
    (erase_done && lock_q && !arm_ok) |=> (pend_q && lock_q)) else $error("erase not recorded"); // R7
endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
  import dbg_lock_pkg::*;
#(
  parameter int              W          = CMD_W,
  parameter logic [W-1:0]    ERASE_CODE = CODE_ERASE_ALL
) (
  input  logic         clk,
  input  logic         nv_init_n,
  input  logic         rst_n,
  input  logic         lock_i,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [W-1:0] cmd_code,
  output logic         grant_o,
  output logic         reject_o,
  output logic [W-1:0] code_o
);
  dec_e         dec_q;
  logic [W-1:0] code_q;
  logic         accept;
  dec_e         dec_d;

  assign cmd_ready = nv_init_n && rst_n && (dec_q == DEC_NONE);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    dec_d = DEC_NONE;
    if (accept) begin
      if (!lock_i || cmd_code == ERASE_CODE) dec_d = DEC_GRANT;
      else                                   dec_d = DEC_REJECT;
    end
  end

  always_ff @(posedge clk) begin
    if (!nv_init_n || !rst_n) begin
      dec_q  <= DEC_NONE;
      code_q <= '0;
    end else begin
      dec_q <= dec_d;
      if (accept) code_q <= cmd_code;
    end
  end

  assign grant_o  = (dec_q == DEC_GRANT);
  assign reject_o = (dec_q == DEC_REJECT);
  assign code_o   = code_q;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
    !(grant_o && reject_o)) else $error("grant and reject together"); // R6
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
    accept |=> ((grant_o || reject_o) && !cmd_ready)) else $error("no result after accept"); // R6
  AST_LOCKED_BLOCKS: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
    (accept && lock_i && cmd_code != ERASE_CODE) |=> (reject_o && !grant_o)) else $error("locked op passed"); // R5
  AST_OPEN_GRANTS: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
    (accept && !lock_i) |=> (grant_o && code_o == $past(cmd_code))) else $error("open op refused"); // R2
endmodule

// File: rtl/dbg_sec_lock.sv
module dbg_sec_lock
  import dbg_lock_pkg::*;
#(
  parameter int               W          = CMD_W,
  parameter logic [W-1:0]     ERASE_CODE = CODE_ERASE_ALL
) (
  input  logic         clk,
  input  logic         nv_init_n,
  input  logic         rst_n,
  input  logic         preboot,
  input  logic         fw_arm,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [W-1:0] cmd_code,
  input  logic         erase_done,
  output logic         cmd_grant,
  output logic         cmd_reject,
  output logic [W-1:0] grant_code,
  output logic         locked,
  output logic         clr_pending
);
  logic arm_ok;
  logic lock_s, pend_s;

  dbg_boot_window u_win (
    .clk(clk), .nv_init_n(nv_init_n), .rst_n(rst_n),
    .preboot(preboot), .fw_arm(fw_arm), .arm_ok(arm_ok)
  );

  dbg_lock_store u_store (
    .clk(clk), .nv_init_n(nv_init_n), .rst_n(rst_n),
    .arm_ok(arm_ok), .erase_done(erase_done),
    .lock_o(lock_s), .pend_o(pend_s)
  );

  dbg_cmd_gate #(.W(W), .ERASE_CODE(ERASE_CODE)) u_gate (
    .clk(clk), .nv_init_n(nv_init_n), .rst_n(rst_n), .lock_i(lock_s),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .grant_o(cmd_grant), .reject_o(cmd_reject), .code_o(grant_code)
  );

  assign locked      = lock_s;
  assign clr_pending = pend_s;

  AST_ARM_IN_PREBOOT: assert property (@(posedge clk) disable iff (!nv_init_n)
    $rose(locked) |-> $past(fw_arm && preboot)) else $error("armed outside preboot"); // R3
  AST_NO_READY_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !cmd_ready) else $error("ready during reset"); // R1
endmodule

// File: tb/dbg_sec_lock_bench.sv
module dbg_sec_lock_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic nv_init_n, rst_n, preboot, fw_arm, cmd_valid, erase_done;
  logic [2:0] cmd_code;
  logic cmd_ready, cmd_grant, cmd_reject, locked, clr_pending;
  logic [2:0] grant_code;
  int checks = 0, errors = 0;
  bit done = 0;

  dbg_sec_lock u_dbg_sec_lock (
    .clk(clk), .nv_init_n(nv_init_n), .rst_n(rst_n), .preboot(preboot),
    .fw_arm(fw_arm), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .erase_done(erase_done), .cmd_grant(cmd_grant),
    .cmd_reject(cmd_reject), .grant_code(grant_code), .locked(locked),
    .clr_pending(clr_pending)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chip_reset(input logic pb);
    @(negedge clk); rst_n = 1'b0; preboot = pb;
    @(negedge clk);
    chk("R1 ready in reset", cmd_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [2:0] c, input logic g, input string req);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    chk({req, " ready"}, cmd_ready, 1);
    @(negedge clk); cmd_valid = 1'b0;
    chk({req, " grant"}, cmd_grant, g);
    chk({req, " reject"}, cmd_reject, !g);
    chk("R6 ready low after accept", cmd_ready, 0);
    if (g) chk("R2 grant_code", grant_code, c);
    @(negedge clk);
    chk("R6 pulse one cycle", {cmd_grant, cmd_reject}, 0);
  endtask

  task automatic arm;
    @(negedge clk); fw_arm = 1'b1;
    @(negedge clk); fw_arm = 1'b0;
  endtask

  task automatic t_init;
    nv_init_n = 0; rst_n = 0; preboot = 1; fw_arm = 0; cmd_valid = 0;
    erase_done = 0; cmd_code = 0;
    repeat (3) @(negedge clk);
    chk("R1 locked init", locked, 0);
    chk("R1 pending init", clr_pending, 0);
    chk("R1 no pulses", {cmd_grant, cmd_reject}, 0);
    nv_init_n = 1;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_open_grants;
    for (int c = 0; c < 8; c++) send(c[2:0], 1'b1, "R2 open");
  endtask

  task automatic t_late_arm;
    chip_reset(1'b1);
    @(negedge clk); preboot = 1'b0;
    @(negedge clk); preboot = 1'b1;
    arm;
    @(negedge clk);
    chk("R4 late arm ignored", locked, 0);
    preboot = 1'b0;
    arm;
    chk("R4 arm outside preboot", locked, 0);
  endtask

  task automatic t_arm;
    chip_reset(1'b1);
    arm;
    chk("R3 armed in window", locked, 1);
    preboot = 1'b0;
  endtask

  task automatic t_locked_filter;
    for (int c = 0; c < 7; c++) send(c[2:0], 1'b0, "R5 blocked");
    send(3'b111, 1'b1, "R5 erase allowed");
  endtask

  task automatic t_reset_no_erase;
    chip_reset(1'b0);
    chk("R8 reset keeps lock", locked, 1);
    send(3'd1, 1'b0, "R8 still blocked");
  endtask

  task automatic t_erase_then_reset;
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    chk("R7 pending set", clr_pending, 1);
    chk("R7 lock held", locked, 1);
    send(3'd2, 1'b0, "R7 blocked before reset");
    chip_reset(1'b0);
    chk("R8 lock cleared", locked, 0);
    chk("R8 pending consumed", clr_pending, 0);
    send(3'd2, 1'b1, "R8 open after clear");
  endtask

  task automatic t_erase_unlocked;
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    chk("R7 no pending when open", clr_pending, 0);
  endtask

  task automatic t_arm_cancels;
    chip_reset(1'b1);
    arm;
    chk("R9 locked", locked, 1);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    chk("R9 pending", clr_pending, 1);
    arm;
    chk("R9 pending cancelled", clr_pending, 0);
    chip_reset(1'b0);
    chk("R9 lock survives", locked, 1);
  endtask

  initial begin
    t_init;
    t_open_grants;
    t_erase_unlocked;
    t_late_arm;
    t_arm;
    t_locked_filter;
    t_reset_no_erase;
    t_erase_then_reset;
    t_arm_cancels;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule